// File: doc/BRIEF.md
# System Exception State and Control Registers

This block keeps the pending, active and enable state of a processor core's system exceptions. It tracks eight of them: the non-maskable interrupt, the memory-manage fault, the bus fault, the usage fault, the supervisor call, the debug monitor, the deferred service request and the system tick. Software reaches this state through a word-addressed register port with a 12-bit byte offset. The port gives a combined control/state word, a handler status word, three words of handler priorities, a vector-base word and a keyed reset-control word.

The core sends an acknowledge strobe when it enters an exception and a complete strobe when it returns from one. Each strobe carries the vector number. The block keeps a small nesting stack of entered vectors. From that stack it reports the running vector and whether a return would leave exception context altogether. Entry and exit go through a three-state nesting machine: `NS_IDLE` (nothing active), `NS_BASE` (one level) and `NS_NESTED` (two or more levels). Its transitions are ENTER (`NS_IDLE`→`NS_BASE` on acknowledge), PREEMPT (`NS_BASE`→`NS_NESTED` on acknowledge), DEEPEN (`NS_NESTED` stays on acknowledge), UNWIND (`NS_NESTED`→`NS_BASE` on complete at depth 2) and EXIT (`NS_BASE`→`NS_IDLE` on complete). The external interrupt controller supplies the highest pending vector and a summary flag, and this block only reflects them. Handler priorities are presented on a flat output bus for the priority arbiter.

Top module: `sysexc_regfile`

## Requirements
- R1: After reset, the control/state word (offset 0xD04) reads 0x0000_0800 when the external inputs are zero. The handler status word (0xD24), the vector base (0xD08) and all priority words read zero, and `sys_reset_req` and `reg_err` are low.
- R2: A write to 0xD04 acts on three exceptions. Bit 31 sets NMI pending. Bit 28 sets deferred-service pending, and bit 27 clears it only when bit 28 is zero. Bit 26 sets tick pending, and bit 25 clears it only when bit 26 is zero. The register has no way to clear NMI pending.
- R3: A read of 0xD04 returns the following. Bits [VEC_W-1:0] hold the running vector, or 0 when nothing is active. Bit 11 holds the return-to-base flag. Bits [12+VEC_W-1:12] hold `ext_pend_vec`, and bit 22 holds `ext_pend_any`. Bits 26, 28 and 31 hold the pending state of the tick (vector 15), the deferred service (vector 14) and the NMI (vector 2).
- R4: A pulse on `exc_raise[s]` sets the pending state of slot s. The slots, in order 0 to 7, are vectors 2, 4, 5, 6, 11, 12, 14 and 15. An acknowledge of a tracked vector clears its pending state and sets its active state, and a complete clears its active state. A set request wins over a clear in the same cycle. In 0xD24, active is shown at bit 0 (vector 4), 1 (5), 3 (6), 7 (11), 8 (12), 10 (14) and 11 (15). Pending is shown at bit 12 (6), 13 (4), 14 (5) and 15 (11).
- R5: Every acknowledge, including one for an external vector of 16 or more, pushes onto a stack of NEST_DEPTH entries, and every complete pops it. The running vector is the top of the stack. The return-to-base flag is 1 at depth 0 or 1 and 0 at depth 2 or more.
- R6: In 0xD24, only bits 16, 17 and 18 are writable. They are the enables of vectors 4, 5 and 6 and read back as written. Writing other bits of 0xD24 changes no pending or active state.
- R7: The words at 0xD18, 0xD1C and 0xD20 each hold four byte-wide handler priorities, with the lower vector in the lower byte. 0xD18 byte 0 belongs to vector 4, so the three words cover vectors 4 to 15. The priority of vector v appears on `hnd_pri[(v-4)*PRI_W +: PRI_W]`.
- R8: The vector base at 0xD08 keeps the written value with bits [6:0] read as zero.
- R9: Offset 0xD0C reads 0xFA05_0000. A write whose bits [31:16] equal 0x05FA and that has bit 0 or bit 2 set raises `sys_reset_req` for exactly one cycle, on the clock edge that takes the write. Any other write to 0xD0C has no effect.
- R10: An access to any other offset reads zero and changes no state. On the clock edge that takes the access, `reg_err` rises for one cycle. Implemented offsets never raise `reg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| reg_err | output | 1 | One-cycle pulse after an access to an unimplemented offset |
| exc_raise | input | 8 | Per-slot pending set requests from the core |
| ack_valid | input | 1 | Exception entry strobe |
| ack_vec | input | VEC_W (9) | Vector being entered |
| cmp_valid | input | 1 | Exception return strobe |
| cmp_vec | input | VEC_W (9) | Vector being returned from |
| ext_pend_vec | input | VEC_W (9) | Highest pending vector from the interrupt controller |
| ext_pend_any | input | 1 | Some external interrupt is pending |
| hnd_pri | output | 12*PRI_W (96) | Priorities of vectors 4 to 15, vector 4 lowest |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that the core is well behaved. It completes only the vector on top of the nesting stack, never acknowledges and completes in the same cycle, and never acknowledges more than NEST_DEPTH levels deep. The bench follows these rules. It raises a vector before it acknowledges it, it completes vectors in the reverse order of entry, and its deepest nesting sequence stops at exactly NEST_DEPTH. Register accesses go one at a time, with a read and a write never in the same cycle. Raise pulses are never issued in the same cycle as an acknowledge of the same vector.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;

    // Vector numbers of the tracked system exceptions
    localparam int V_NMI    = 2;
    localparam int V_MEM    = 4;
    localparam int V_BUS    = 5;
    localparam int V_USAGE  = 6;
    localparam int V_SVC    = 11;
    localparam int V_DEBUG  = 12;
    localparam int V_PENDSV = 14;
    localparam int V_TICK   = 15;

    // Tracked slots; slot order is the order of exc_raise bits
    localparam int NSLOT = 8;
    localparam int SLOT_VEC [NSLOT] = '{V_NMI, V_MEM, V_BUS, V_USAGE,
                                        V_SVC, V_DEBUG, V_PENDSV, V_TICK};

    // Handler priority coverage: vectors 4..15
    localparam int PRI_FIRST = 4;
    localparam int PRI_COUNT = 12;
    localparam int PRI_WORDS = 3;

    // Register offsets
    localparam logic [11:0] OFS_CTRL  = 12'hD04;
    localparam logic [11:0] OFS_VBASE = 12'hD08;
    localparam logic [11:0] OFS_RSTC  = 12'hD0C;
    localparam logic [11:0] OFS_PRI0  = 12'hD18;
    localparam logic [11:0] OFS_PRI1  = 12'hD1C;
    localparam logic [11:0] OFS_PRI2  = 12'hD20;
    localparam logic [11:0] OFS_HSTAT = 12'hD24;

    localparam logic [15:0] WR_KEY = 16'h05FA;
    localparam logic [15:0] RD_KEY = 16'hFA05;

    typedef enum logic [1:0] {
        NS_IDLE   = 2'd0,
        NS_BASE   = 2'd1,
        NS_NESTED = 2'd2
    } nest_state_e;

    // Decoded software requests from the control/state word
    typedef struct packed {
        logic nmi_set;
        logic psv_set;
        logic psv_clr;
        logic tick_set;
        logic tick_clr;
    } ctrl_wr_t;

endpackage

// File: rtl/sysexc_nest.sv
module sysexc_nest
    import sysexc_pkg::*;
#(
    parameter int VEC_W      = 9,
    parameter int NEST_DEPTH = 4,
    localparam int DW        = $clog2(NEST_DEPTH + 1),
    localparam int IW        = (NEST_DEPTH > 1) ? $clog2(NEST_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [VEC_W-1:0] push_vec,
    input  logic             pop,
    output logic [VEC_W-1:0] top_vec,
    output logic [DW-1:0]    depth,
    output logic             ret_base
);

    nest_state_e state_q, state_n;
    logic [DW-1:0] depth_q;
    logic          push_ok, pop_ok, grow, shrink;
    logic [IW-1:0] wr_idx, top_idx;
    logic [VEC_W-1:0] stk [NEST_DEPTH];

    assign push_ok = push && (depth_q < DW'(NEST_DEPTH));
    assign pop_ok  = pop && (depth_q != '0);
    assign grow    = push_ok && !pop_ok;
    assign shrink  = pop_ok && !push_ok;
    assign top_idx = IW'(depth_q - DW'(1));
    assign wr_idx  = pop_ok ? top_idx : IW'(depth_q);

    // Stack storage, one register per level
    generate
        for (genvar i = 0; i < NEST_DEPTH; i++) begin : g_lvl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stk[i] <= '0;
                else if (push_ok && (wr_idx == IW'(i)))
                    stk[i] <= push_vec;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            depth_q <= '0;
        else if (grow)
            depth_q <= depth_q + DW'(1);
        else if (shrink)
            depth_q <= depth_q - DW'(1);
    end

    // Nesting state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= NS_IDLE;
        else
            state_q <= state_n;
    end

    // Transitions: ENTER, PREEMPT, DEEPEN, UNWIND, EXIT
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            NS_IDLE: begin
                if (grow) state_n = NS_BASE;                 // ENTER
            end
            NS_BASE: begin
                if (grow)        state_n = NS_NESTED;        // PREEMPT
                else if (shrink) state_n = NS_IDLE;          // EXIT
            end
            NS_NESTED: begin
                if (shrink && (depth_q == DW'(2)))
                    state_n = NS_BASE;                       // UNWIND
            end                                              // DEEPEN: stay
            default: state_n = NS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ret_base = (state_q != NS_NESTED);
        depth    = depth_q;
        top_vec  = (depth_q == '0) ? '0 : stk[top_idx];
    end

endmodule

// File: rtl/sysexc_state.sv
module sysexc_state
    import sysexc_pkg::*;
#(
    parameter int VEC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_wr_t         sw,
    input  logic             en_we,
    input  logic [2:0]       en_wdata,
    input  logic [NSLOT-1:0] raise,
    input  logic             ack_valid,
    input  logic [VEC_W-1:0] ack_vec,
    input  logic             cmp_valid,
    input  logic [VEC_W-1:0] cmp_vec,
    output logic [NSLOT-1:0] pend,
    output logic [NSLOT-1:0] act,
    output logic [2:0]       en
);

    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            localparam int V = SLOT_VEC[s];
            logic p_q, a_q, set_p, clr_p, hit_ack, hit_cmp;

            assign hit_ack = ack_valid && (ack_vec == VEC_W'(V));
            assign hit_cmp = cmp_valid && (cmp_vec == VEC_W'(V));
            assign set_p   = raise[s]
                           | ((V == V_NMI)    && sw.nmi_set)
                           | ((V == V_PENDSV) && sw.psv_set)
                           | ((V == V_TICK)   && sw.tick_set);
            assign clr_p   = hit_ack
                           | ((V == V_PENDSV) && sw.psv_clr)
                           | ((V == V_TICK)   && sw.tick_clr);

            // Set wins over clear
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    p_q <= 1'b0;
                    a_q <= 1'b0;
                end else begin
                    if (set_p)      p_q <= 1'b1;
                    else if (clr_p) p_q <= 1'b0;
                    if (hit_ack)      a_q <= 1'b1;
                    else if (hit_cmp) a_q <= 1'b0;
                end
            end

            assign pend[s] = p_q;
            assign act[s]  = a_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en <= '0;
        else if (en_we)
            en <= en_wdata;
    end

endmodule

// File: rtl/sysexc_regs.sv
module sysexc_regs
    import sysexc_pkg::*;
#(
    parameter int VEC_W = 9,
    parameter int PRI_W = 8,
    localparam int PRI_BUS_W = PRI_COUNT * PRI_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_rd,
    input  logic                 reg_wr,
    input  logic [11:0]          reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 reg_err,
    input  logic [NSLOT-1:0]     pend,
    input  logic [NSLOT-1:0]     act,
    input  logic [2:0]           en,
    input  logic [VEC_W-1:0]     top_vec,
    input  logic                 ret_base,
    input  logic [VEC_W-1:0]     ext_pend_vec,
    input  logic                 ext_pend_any,
    output ctrl_wr_t             sw,
    output logic                 en_we,
    output logic [2:0]           en_wdata,
    output logic [PRI_BUS_W-1:0] hnd_pri,
    output logic                 sys_reset_req
);

    localparam logic [11:0] PRI_OFS [PRI_WORDS] = '{OFS_PRI0, OFS_PRI1, OFS_PRI2};

    logic [31:7] vbase_q;
    logic        hit, err_q, rst_q, key_ok;
    logic [31:0] ctrl_word, stat_word;
    logic [31:0] pri_word [PRI_WORDS];

    // Write decode
    always_comb begin
        sw          = '0;
        sw.nmi_set  = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[31];
        sw.psv_set  = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[28];
        sw.psv_clr  = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[27] && !reg_wdata[28];
        sw.tick_set = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[26];
        sw.tick_clr = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[25] && !reg_wdata[26];
        en_we       = reg_wr && (reg_addr == OFS_HSTAT);
        en_wdata    = reg_wdata[18:16];
        key_ok      = reg_wr && (reg_addr == OFS_RSTC) && (reg_wdata[31:16] == WR_KEY);
    end

    // Priority bytes: word r, byte b covers vector 4 + 4r + b
    generate
        for (genvar r = 0; r < PRI_WORDS; r++) begin : g_word
            for (genvar b = 0; b < 4; b++) begin : g_byte
                localparam int K = r * 4 + b;
                logic [PRI_W-1:0] pri_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        pri_q <= '0;
                    else if (reg_wr && (reg_addr == PRI_OFS[r]))
                        pri_q <= reg_wdata[b*8 +: PRI_W];
                end
                assign hnd_pri[K*PRI_W +: PRI_W] = pri_q;
                assign pri_word[r][b*8 +: 8]     = 8'(pri_q);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vbase_q <= '0;
            err_q   <= 1'b0;
            rst_q   <= 1'b0;
        end else begin
            if (reg_wr && (reg_addr == OFS_VBASE))
                vbase_q <= reg_wdata[31:7];
            err_q <= (reg_rd || reg_wr) && !hit;
            rst_q <= key_ok && (reg_wdata[0] || reg_wdata[2]);
        end
    end

    // Read views
    always_comb begin
        ctrl_word                  = '0;
        ctrl_word[VEC_W-1:0]       = top_vec;
        ctrl_word[11]              = ret_base;
        ctrl_word[12 +: VEC_W]     = ext_pend_vec;
        ctrl_word[22]              = ext_pend_any;
        ctrl_word[26]              = pend[7];
        ctrl_word[28]              = pend[6];
        ctrl_word[31]              = pend[0];

        stat_word                  = '0;
        stat_word[0]               = act[1];
        stat_word[1]               = act[2];
        stat_word[3]               = act[3];
        stat_word[7]               = act[4];
        stat_word[8]               = act[5];
        stat_word[10]              = act[6];
        stat_word[11]              = act[7];
        stat_word[12]              = pend[3];
        stat_word[13]              = pend[1];
        stat_word[14]              = pend[2];
        stat_word[15]              = pend[4];
        stat_word[18:16]           = en;
    end

    always_comb begin
        reg_rdata = '0;
        hit       = 1'b1;
        case (reg_addr)
            OFS_CTRL:  reg_rdata = ctrl_word;
            OFS_VBASE: reg_rdata = {vbase_q, 7'd0};
            OFS_RSTC:  reg_rdata = {RD_KEY, 16'd0};
            OFS_PRI0:  reg_rdata = pri_word[0];
            OFS_PRI1:  reg_rdata = pri_word[1];
            OFS_PRI2:  reg_rdata = pri_word[2];
            OFS_HSTAT: reg_rdata = stat_word;
            default:   hit       = 1'b0;
        endcase
    end

    assign reg_err       = err_q;
    assign sys_reset_req = rst_q;

endmodule

// File: rtl/sysexc_regfile.sv
module sysexc_regfile
    import sysexc_pkg::*;
#(
    parameter int VEC_W      = 9,
    parameter int NEST_DEPTH = 4,
    parameter int PRI_W      = 8,
    localparam int DW        = $clog2(NEST_DEPTH + 1),
    localparam int PRI_BUS_W = PRI_COUNT * PRI_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_rd,
    input  logic                 reg_wr,
    input  logic [11:0]          reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 reg_err,
    input  logic [NSLOT-1:0]     exc_raise,
    input  logic                 ack_valid,
    input  logic [VEC_W-1:0]     ack_vec,
    input  logic                 cmp_valid,
    input  logic [VEC_W-1:0]     cmp_vec,
    input  logic [VEC_W-1:0]     ext_pend_vec,
    input  logic                 ext_pend_any,
    output logic [PRI_BUS_W-1:0] hnd_pri,
    output logic                 sys_reset_req
);

    ctrl_wr_t         sw;
    logic             en_we;
    logic [2:0]       en_wdata, en_bits;
    logic [NSLOT-1:0] pend_bits, act_bits;
    logic [VEC_W-1:0] act_vec;
    logic [DW-1:0]    nest_depth;
    logic             ret_base;

    sysexc_nest #(.VEC_W(VEC_W), .NEST_DEPTH(NEST_DEPTH)) u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ack_valid),
        .push_vec (ack_vec),
        .pop      (cmp_valid),
        .top_vec  (act_vec),
        .depth    (nest_depth),
        .ret_base (ret_base)
    );

    sysexc_state #(.VEC_W(VEC_W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw        (sw),
        .en_we     (en_we),
        .en_wdata  (en_wdata),
        .raise     (exc_raise),
        .ack_valid (ack_valid),
        .ack_vec   (ack_vec),
        .cmp_valid (cmp_valid),
        .cmp_vec   (cmp_vec),
        .pend      (pend_bits),
        .act       (act_bits),
        .en        (en_bits)
    );

    sysexc_regs #(.VEC_W(VEC_W), .PRI_W(PRI_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_rd        (reg_rd),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .reg_err       (reg_err),
        .pend          (pend_bits),
        .act           (act_bits),
        .en            (en_bits),
        .top_vec       (act_vec),
        .ret_base      (ret_base),
        .ext_pend_vec  (ext_pend_vec),
        .ext_pend_any  (ext_pend_any),
        .sw            (sw),
        .en_we         (en_we),
        .en_wdata      (en_wdata),
        .hnd_pri       (hnd_pri),
        .sys_reset_req (sys_reset_req)
    );

endmodule

// File: rtl/sysexc_regfile_chk.sv
module sysexc_regfile_chk
    import sysexc_pkg::*;
#(
    parameter int VEC_W      = 9,
    parameter int NEST_DEPTH = 4,
    localparam int DW        = $clog2(NEST_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_rd,
    input logic             reg_wr,
    input logic [11:0]      reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             reg_err,
    input logic             sys_reset_req,
    input logic [NSLOT-1:0] raise,
    input logic             ack_valid,
    input logic [VEC_W-1:0] ack_vec,
    input logic             cmp_valid,
    input logic [VEC_W-1:0] act_vec,
    input logic [DW-1:0]    depth,
    input logic             ret_base,
    input logic [NSLOT-1:0] pend,
    input logic [NSLOT-1:0] act_bits
);

    AST_RESET_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> ($past(reg_wr) && ($past(reg_addr) == OFS_RSTC)
                           && ($past(reg_wdata[31:16]) == WR_KEY)));   // R9

    AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> $past(reg_rd || reg_wr));   // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DW'(NEST_DEPTH));   // R5

    AST_ACK_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !cmp_valid && (depth < DW'(NEST_DEPTH)))
        |=> (act_vec == $past(ack_vec)));   // R5

    AST_RTB_SHALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (depth <= DW'(1)) |-> ret_base);   // R5

    AST_RTB_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (depth >= DW'(2)) |-> !ret_base);   // R5

    AST_ACT_NEEDS_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|act_bits) |-> (depth != '0));   // R4

    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_ack
            AST_PEND_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_valid && (ack_vec == VEC_W'(SLOT_VEC[s])) && !raise[s] && !reg_wr)
                |=> (!pend[s] && act_bits[s]));   // R4
        end
    endgenerate

endmodule

bind sysexc_regfile sysexc_regfile_chk #(.VEC_W(VEC_W), .NEST_DEPTH(NEST_DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_rd        (reg_rd),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_err       (reg_err),
    .sys_reset_req (sys_reset_req),
    .raise         (exc_raise),
    .ack_valid     (ack_valid),
    .ack_vec       (ack_vec),
    .cmp_valid     (cmp_valid),
    .act_vec       (act_vec),
    .depth         (nest_depth),
    .ret_base      (ret_base),
    .pend          (pend_bits),
    .act_bits      (act_bits)
);

// File: tb/sysexc_regfile_bench.sv
module sysexc_regfile_bench;

    localparam int VEC_W = 9;
    localparam int NEST_DEPTH = 4;
    localparam int PRI_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_err;
    logic [7:0]  exc_raise = '0;
    logic        ack_valid = 1'b0, cmp_valid = 1'b0;
    logic [VEC_W-1:0] ack_vec = '0, cmp_vec = '0;
    logic [VEC_W-1:0] ext_pend_vec = '0;
    logic        ext_pend_any = 1'b0;
    logic [12*PRI_W-1:0] hnd_pri;
    logic        sys_reset_req;

    always #10 clk = ~clk;

    sysexc_regfile #(.VEC_W(VEC_W), .NEST_DEPTH(NEST_DEPTH), .PRI_W(PRI_W)) u_sysexc_regfile (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_err(reg_err), .exc_raise(exc_raise), .ack_valid(ack_valid),
        .ack_vec(ack_vec), .cmp_valid(cmp_valid), .cmp_vec(cmp_vec),
        .ext_pend_vec(ext_pend_vec), .ext_pend_any(ext_pend_any),
        .hnd_pri(hnd_pri), .sys_reset_req(sys_reset_req)
    );

    int checks = 0, errors = 0;
    logic last_err, last_rst;
    logic [15:0] m_pend = '0, m_act = '0;
    logic [2:0]  m_en = '0;
    int m_stk [8];
    int m_dep = 0;
    int slot_vec [8] = '{2, 4, 5, 6, 11, 12, 14, 15};
    logic [31:0] m_pri [3];
    logic [31:0] m_vbase = '0;

    task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    function automatic logic [31:0] ctrl_exp();
        logic [31:0] e = '0;
        int top = (m_dep == 0) ? 0 : m_stk[m_dep-1];
        e[VEC_W-1:0] = VEC_W'(top);
        e[11] = (m_dep <= 1);
        e[20:12] = ext_pend_vec;
        e[22] = ext_pend_any;
        e[26] = m_pend[15];
        e[28] = m_pend[14];
        e[31] = m_pend[2];
        return e;
    endfunction

    function automatic logic [31:0] stat_exp();
        logic [31:0] e = '0;
        e[0] = m_act[4];  e[1] = m_act[5];  e[3] = m_act[6];
        e[7] = m_act[11]; e[8] = m_act[12]; e[10] = m_act[14]; e[11] = m_act[15];
        e[12] = m_pend[6]; e[13] = m_pend[4]; e[14] = m_pend[5]; e[15] = m_pend[11];
        e[18:16] = m_en;
        return e;
    endfunction

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
        last_err = reg_err; last_rst = sys_reset_req;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
        last_err = reg_err;
    endtask

    task automatic chk_rd(input string tag, input logic [11:0] a, input logic [31:0] e);
        logic [31:0] d;
        bus_rd(a, d);
        chk(tag, d, e);
    endtask

    task automatic raise_slot(input int s);
        @(negedge clk); exc_raise[s] = 1'b1;
        @(negedge clk); exc_raise[s] = 1'b0;
        m_pend[slot_vec[s]] = 1'b1;
    endtask

    task automatic do_ack(input int v);
        @(negedge clk); ack_valid = 1'b1; ack_vec = VEC_W'(v);
        @(negedge clk); ack_valid = 1'b0;
        if (v < 16) begin m_pend[v] = 1'b0; m_act[v] = 1'b1; end
        m_stk[m_dep] = v; m_dep++;
    endtask

    task automatic do_cmp(input int v);
        @(negedge clk); cmp_valid = 1'b1; cmp_vec = VEC_W'(v);
        @(negedge clk); cmp_valid = 1'b0;
        if (v < 16) m_act[v] = 1'b0;
        m_dep--;
    endtask

    task automatic chk_pri(input string tag);
        for (int r = 0; r < 3; r++) begin
            chk(tag, 0, 0);
            checks--;
            chk_rd(tag, 12'hD18 + 12'(4*r), m_pri[r]);
            for (int b = 0; b < 4; b++)
                chk({tag, " bus"}, 32'(hnd_pri[(4*r+b)*PRI_W +: PRI_W]), 32'(m_pri[r][8*b +: 8]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int r = 0; r < 3; r++) m_pri[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 ctrl", reg_rdata, reg_rdata);
        checks--;
        chk_rd("R1 ctrl", 12'hD04, 32'h0000_0800);
        chk_rd("R1 stat", 12'hD24, 32'h0);
        chk_rd("R1 vbase", 12'hD08, 32'h0);
        chk_pri("R1 pri");
        chk("R1 rstreq", 32'(sys_reset_req), 32'h0);
        chk("R1 err", 32'(last_err), 32'h0);

        // R2 exhaustive set/clear combinations on the control word
        for (int k = 0; k < 32; k++) begin
            logic [31:0] w = '0;
            w[31] = k[4]; w[28] = k[3]; w[27] = k[2]; w[26] = k[1]; w[25] = k[0];
            if (k[4]) m_pend[2] = 1'b1;
            if (k[3]) m_pend[14] = 1'b1; else if (k[2]) m_pend[14] = 1'b0;
            if (k[1]) m_pend[15] = 1'b1; else if (k[0]) m_pend[15] = 1'b0;
            bus_wr(12'hD04, w);
            chk("R2 ctrl set/clear", 0, 0); checks--;
            chk_rd("R2 ctrl set/clear", 12'hD04, ctrl_exp());
        end

        // R3 external fields reflected
        for (int v = 0; v < 512; v += 37) begin
            ext_pend_vec = VEC_W'(v);
            ext_pend_any = v[0];
            chk_rd("R3 ctrl ext fields", 12'hD04, ctrl_exp());
        end

        // R6 only enable bits writable
        for (int k = 0; k < 8; k++) begin
            logic [31:0] w = 32'hFFFF_FFFF;
            w[18:16] = 3'(k);
            m_en = 3'(k);
            bus_wr(12'hD24, w);
            chk_rd("R6 stat enables", 12'hD24, stat_exp());
        end

        // R4 raise / acknowledge / complete per slot
        for (int s = 0; s < 8; s++) begin
            int v = slot_vec[s];
            raise_slot(s);
            chk_rd("R4 stat raised", 12'hD24, stat_exp());
            chk_rd("R4 ctrl raised", 12'hD04, ctrl_exp());
            do_ack(v);
            chk_rd("R4 stat acked", 12'hD24, stat_exp());
            chk_rd("R4 ctrl acked", 12'hD04, ctrl_exp());
            do_cmp(v);
            chk_rd("R4 stat done", 12'hD24, stat_exp());
            chk_rd("R4 ctrl done", 12'hD04, ctrl_exp());
        end

        // R5 nesting to full depth and unwinding
        raise_slot(1);
        do_ack(37);  chk_rd("R5 depth1", 12'hD04, ctrl_exp());
        do_ack(40);  chk_rd("R5 depth2", 12'hD04, ctrl_exp());
        do_ack(4);   chk_rd("R5 depth3", 12'hD04, ctrl_exp());
        chk_rd("R5 stat nested", 12'hD24, stat_exp());
        do_ack(70);  chk_rd("R5 depth4", 12'hD04, ctrl_exp());
        do_cmp(70);  chk_rd("R5 pop3", 12'hD04, ctrl_exp());
        do_cmp(4);   chk_rd("R5 pop2", 12'hD04, ctrl_exp());
        chk_rd("R5 stat popped", 12'hD24, stat_exp());
        do_cmp(40);  chk_rd("R5 pop1", 12'hD04, ctrl_exp());
        do_cmp(37);  chk_rd("R5 pop0", 12'hD04, ctrl_exp());

        // R7 priority words and bus positions
        for (int r = 0; r < 3; r++) begin
            for (int b = 0; b < 4; b++)
                m_pri[r][8*b +: 8] = 8'((4*r + b) * 17 + 3);
            bus_wr(12'hD18 + 12'(4*r), m_pri[r]);
        end
        chk_pri("R7 pri");
        m_pri[1] = 32'hFFFF_FFFF;
        bus_wr(12'hD1C, m_pri[1]);
        chk_pri("R7 pri overwrite");
        chk("R7 vector4 byte", 32'(hnd_pri[0 +: PRI_W]), 32'd3);

        // R8 vector base alignment
        bus_wr(12'hD08, 32'hFFFF_FFFF); m_vbase = 32'hFFFF_FF80;
        chk_rd("R8 vbase", 12'hD08, m_vbase);
        bus_wr(12'hD08, 32'h2000_007F); m_vbase = 32'h2000_0000;
        chk_rd("R8 vbase", 12'hD08, m_vbase);
        bus_wr(12'hD08, 32'h1234_5678); m_vbase = 32'h1234_5600;
        chk_rd("R8 vbase", 12'hD08, m_vbase);

        // R9 keyed reset control
        chk_rd("R9 rstc read", 12'hD0C, 32'hFA05_0000);
        bus_wr(12'hD0C, 32'h05FA_0001);
        chk("R9 keyed bit0 pulse", 32'(last_rst), 32'h1);
        @(negedge clk);
        chk("R9 pulse one cycle", 32'(sys_reset_req), 32'h0);
        bus_wr(12'hD0C, 32'h05FA_0004);
        chk("R9 keyed bit2 pulse", 32'(last_rst), 32'h1);
        bus_wr(12'hD0C, 32'h05FA_0002);
        chk("R9 keyed bit1 only", 32'(last_rst), 32'h0);
        bus_wr(12'hD0C, 32'h1234_0005);
        chk("R9 bad key", 32'(last_rst), 32'h0);
        bus_wr(12'hD0C, 32'hFA05_0005);
        chk("R9 read key on write", 32'(last_rst), 32'h0);

        // R10 unimplemented offsets
        begin
            logic [11:0] bad [5] = '{12'hD00, 12'hD10, 12'hD28, 12'hD06, 12'h010};
            for (int i = 0; i < 5; i++) begin
                chk_rd("R10 bad read zero", bad[i], 32'h0);
                chk("R10 read err", 32'(last_err), 32'h1);
                bus_wr(bad[i], 32'hFFFF_FFFF);
                chk("R10 write err", 32'(last_err), 32'h1);
                chk("R10 write no reset", 32'(last_rst), 32'h0);
            end
            chk_rd("R10 vbase untouched", 12'hD08, m_vbase);
            chk("R10 good read no err", 32'(last_err), 32'h0);
            chk_rd("R10 stat untouched", 12'hD24, stat_exp());
            chk_rd("R10 ctrl untouched", 12'hD04, ctrl_exp());
            chk_pri("R10 pri untouched");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule